// File: doc/BRIEF.md
# Guarded Pulse-Width Modulator with Centred Sample Strobe

This block drives the main switch of a single-switch DC-DC converter. A free-running counter steps through a 512-clock period, which gives about 195 kHz from a 100 MHz clock. A 9-bit on-time command sets how many clocks of each period the gate output is high, so each count is 1/512 of the period. The command is taken only at the period boundary. A one-clock strobe marks the centre of each on-interval. The output-voltage converter is triggered there, well away from the switching edges.

Two guards sit between the counter and the gate. The first is an undervoltage lockout. It watches a 12-bit input-voltage code and uses separate rising and falling thresholds, so there is hysteresis. A status output reports when the block is locked out. The second is a cycle-level overcurrent guard. It ends the present pulse as soon as the flag is seen. It lets pulses resume at the next period start, but only if the flag has cleared by then.

Top module: `pwm_guarded`

## Requirements
- R1: The period is 512 clocks. Phase p of a period is seen in `gate_out` in the cycle after rising edge n, where p = (n-1) mod 512 and n counts edges from the first one after reset release. With command D latched, `gate_out` is high exactly in phases 0 to D-1. D=0 never pulses and D=511 gives 511 high phases.
- R2: `duty_cmd` is latched only at the last phase of a period. A change made mid-period changes the next period only.
- R3: `sample_stb` is high for exactly one cycle, at phase floor(D/2), and only while the pulse of that period is still on. No strobe is issued for D=0 or for a pulse that was ended earlier.
- R4: The lockout is released when `vin_code` is above `UV_RISE` (strictly greater) and asserted when `vin_code` is below `UV_FALL` (strictly less). A value between the two thresholds, or equal to one of them, keeps the present state.
- R5: While `lockout` is high, `gate_out` is low from the following cycle on. A lockout taken at phase j of a pulse with D > j+1 leaves j+2 high phases.
- R6: After a lockout is released, no pulse starts within the remainder of that period. Pulses begin at the next period start.
- R7: An `oc_flag` sampled high ends the pulse in the next cycle. When the flag is raised in the cycle showing phase j < D, the period has j+1 high phases. Clearing the flag does not restart the pulse within the same period.
- R8: If `oc_flag` is low at the last phase of a period, the next period pulses normally. If it is still high there, the whole next period stays low.
- R9: During and right after reset, `gate_out` and `sample_stb` are low and `lockout` is high. The counter starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switching-domain clock |
| rst_n | input | 1 | Synchronous active-low reset |
| duty_cmd | input | 9 | On-time command in clocks per period |
| vin_code | input | 12 | Input-voltage converter code |
| oc_flag | input | 1 | Primary overcurrent flag, synchronous, active high |
| gate_out | output | 1 | Main switch gate command |
| sample_stb | output | 1 | One-clock strobe at the centre of the on-interval |
| lockout | output | 1 | High while the undervoltage lockout holds the gate off |

## Verification
The pulse generator is run with commands 0, 1, 2, 255, 256, 511 and mid-range values. These show whether the high count is off by one, whether the strobe position rounds down for odd and even commands, and whether the extreme commands wrap or go missing. Overcurrent pulses are applied before the centre, after the centre, after the pulse has already ended, and across a period boundary. This tells a truncated pulse apart from a lost strobe, a premature restart and a blanked period. The voltage code is placed exactly on each threshold, one count past it, and changed mid-period. This separates correct hysteresis from a single-threshold compare and from a release that starts a partial pulse.

// File: rtl/pwm_guarded_pkg.sv
// Shared definitions for the guarded PWM.
// Assumes: all users compile this package first.
package pwm_guarded_pkg;

    // Output pair produced by the gate stage.
    typedef struct packed {
        logic gate;
        logic stb;
    } pgd_drive_t;

endpackage

// File: rtl/pgd_timebase.sv
// Period counter and on-time command latch.
// The counter wraps naturally at 2**CNT_W. The command is captured on the
// last count of each period, so a new value only ever applies from count 0.
// Assumes: duty_cmd is synchronous to clk.
module pgd_timebase #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] duty_cmd,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] duty_q,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] CNT_LAST = {CNT_W{1'b1}};

    assign wrap = (cnt == CNT_LAST);

    // Free-running period counter.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end

    // Capture the command at the period boundary only.
    always_ff @(posedge clk) begin
        if (!rst_n)    duty_q <= '0;
        else if (wrap) duty_q <= duty_cmd;
    end
endmodule

// File: rtl/pgd_uvlo.sv
// Undervoltage lockout with hysteresis on a digital input-voltage code.
// Leaves lockout when the code is above RISE, enters it when below FALL.
// Assumes: FALL < RISE and vin_code is synchronous to clk.
module pgd_uvlo #(
    parameter int VIN_W = 12,
    parameter int RISE  = 1877,
    parameter int FALL  = 1775
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VIN_W-1:0] vin_code,
    output logic             locked
);
    localparam logic [VIN_W-1:0] RISE_C = VIN_W'(RISE);
    localparam logic [VIN_W-1:0] FALL_C = VIN_W'(FALL);

    // Lockout state: starts locked, moves only across the matching threshold.
    always_ff @(posedge clk) begin
        if (!rst_n)                              locked <= 1'b1;
        else if (locked && (vin_code > RISE_C))  locked <= 1'b0;
        else if (!locked && (vin_code < FALL_C)) locked <= 1'b1;
    end
endmodule

// File: rtl/pgd_gate.sv
// Gate and sample-strobe stage with per-period blanking.
// A block flag is raised by overcurrent or lockout and is re-evaluated only
// at the period boundary, so a pulse never restarts mid-period.
// Assumes: cnt, duty_q and wrap come from pgd_timebase.
module pgd_gate
    import pwm_guarded_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] duty_q,
    input  logic             wrap,
    input  logic             oc_flag,
    input  logic             locked,
    output pgd_drive_t       drive
);
    logic blk;
    logic live;
    logic [CNT_W-1:0] mid;

    assign live = !blk && !oc_flag && !locked;
    assign mid  = duty_q >> 1;

    // Per-period blanking: accumulate faults, re-arm only at the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)    blk <= 1'b1;
        else if (wrap) blk <= oc_flag | locked;
        else           blk <= blk | oc_flag | locked;
    end

    // Registered gate and centre strobe, so no comparator glitch reaches the pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drive <= '0;
        end else begin
            drive.gate <= live && (cnt < duty_q);
            drive.stb  <= live && (duty_q != '0) && (cnt == mid);
        end
    end
endmodule

// File: rtl/pwm_guarded.sv
// Guarded pulse-width modulator: period counter, undervoltage lockout and
// gate stage with overcurrent blanking and a centred sample strobe.
// Assumes: all inputs synchronous to clk; synchronous active-low reset.
module pwm_guarded
    import pwm_guarded_pkg::*;
#(
    parameter int CNT_W   = 9,
    parameter int VIN_W   = 12,
    parameter int UV_RISE = 1877,
    parameter int UV_FALL = 1775
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] duty_cmd,
    input  logic [VIN_W-1:0] vin_code,
    input  logic             oc_flag,
    output logic             gate_out,
    output logic             sample_stb,
    output logic             lockout
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] duty_q;
    logic             wrap;
    logic             locked;
    pgd_drive_t       drive;

    pgd_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .duty_cmd(duty_cmd),
        .cnt(cnt), .duty_q(duty_q), .wrap(wrap)
    );

    pgd_uvlo #(.VIN_W(VIN_W), .RISE(UV_RISE), .FALL(UV_FALL)) u_uv (
        .clk(clk), .rst_n(rst_n), .vin_code(vin_code), .locked(locked)
    );

    pgd_gate #(.CNT_W(CNT_W)) u_gt (
        .clk(clk), .rst_n(rst_n), .cnt(cnt), .duty_q(duty_q), .wrap(wrap),
        .oc_flag(oc_flag), .locked(locked), .drive(drive)
    );

    assign gate_out   = drive.gate;
    assign sample_stb = drive.stb;
    assign lockout    = locked;
endmodule

// File: rtl/pwm_guarded_chk.sv
// Temporal checks for pwm_guarded, attached by bind.
// Assumes: cnt is the period counter inside the top module.
module pwm_guarded_chk #(
    parameter int CNT_W   = 9,
    parameter int VIN_W   = 12,
    parameter int UV_RISE = 1877,
    parameter int UV_FALL = 1775
) (
    input logic             clk,
    input logic             rst_n,
    input logic [VIN_W-1:0] vin_code,
    input logic             oc_flag,
    input logic             gate_out,
    input logic             sample_stb,
    input logic             lockout,
    input logic [CNT_W-1:0] cnt
);
    // R1: a pulse can only begin at the start of a period.
    p_rise_at_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_out) |-> (cnt == CNT_W'(1)));

    // R3: the strobe only occurs inside a live pulse and is one clock wide.
    p_stb_in_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> gate_out);
    p_stb_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> !sample_stb);

    // R4: release needs a code above the rising threshold, entry one below the falling one.
    p_release_thr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lockout) |-> ($past(vin_code) > VIN_W'(UV_RISE)));
    p_entry_thr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lockout) |-> ($past(vin_code) < VIN_W'(UV_FALL)));

    // R5: lockout holds the gate low.
    p_lock_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lockout |=> !gate_out);

    // R7: an overcurrent flag ends the pulse in the next cycle.
    p_oc_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        oc_flag |=> !gate_out);
endmodule

bind pwm_guarded pwm_guarded_chk #(
    .CNT_W(CNT_W), .VIN_W(VIN_W), .UV_RISE(UV_RISE), .UV_FALL(UV_FALL)
) u_chk (
    .clk(clk), .rst_n(rst_n), .vin_code(vin_code), .oc_flag(oc_flag),
    .gate_out(gate_out), .sample_stb(sample_stb), .lockout(lockout), .cnt(cnt)
);

// File: tb/tb_pwm_guarded.sv
module tb_pwm_guarded;
    localparam int PER  = 512;
    localparam int RISE = 1877;
    localparam int FALL = 1775;
    localparam int NV   = 15;

    // duty, oc_on, oc_off, dchg_phase, dchg_val, exp_highs, exp_stb_phase (-1: none)
    localparam int VEC [NV][7] = '{
        '{  0,  -1,  -1, -1,  -1,   0,  -1},
        '{  1,  -1,  -1, -1,  -1,   1,   0},
        '{  2,  -1,  -1, -1,  -1,   2,   1},
        '{255,  -1,  -1, -1,  -1, 255, 127},
        '{256,  -1,  -1, -1,  -1, 256, 128},
        '{511,  -1,  -1, -1,  -1, 511, 255},
        '{100,  -1,  -1, 50, 400, 100,  50},
        '{400,  -1,  -1, -1,  -1, 400, 200},
        '{300, 100, 120, -1,  -1, 101,  -1},
        '{300,  -1,  -1, -1,  -1, 300, 150},
        '{400, 250, 260, -1,  -1, 251, 200},
        '{100, 200, 210, -1,  -1, 100,  50},
        '{300,  40,  -1, -1,  -1,  41,  -1},
        '{300,  -1,  50, -1,  -1,   0,  -1},
        '{300,  -1,  -1, -1,  -1, 300, 150}
    };
    localparam string TAG [NV] = '{
        "R1/R3", "R1/R3", "R1/R3", "R1/R3", "R1/R3", "R1/R3", "R2",
        "R2", "R7", "R8", "R7", "R7", "R7", "R8", "R8"
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [8:0]  duty_cmd;
    logic [11:0] vin_code;
    logic        oc_flag;
    logic        gate_out, sample_stb, lockout;

    int checks = 0;
    int fails  = 0;
    int edges  = 0;
    bit done   = 1'b0;

    pwm_guarded dut (
        .clk(clk), .rst_n(rst_n), .duty_cmd(duty_cmd), .vin_code(vin_code),
        .oc_flag(oc_flag), .gate_out(gate_out), .sample_stb(sample_stb),
        .lockout(lockout)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) edges <= 0;
        else        edges <= edges + 1;
    end

    function automatic int phase();
        return (edges - 1) % PER;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Observe one full period, applying optional mid-period stimulus.
    task automatic measure(input int oc_on, input int oc_off, input int dph, input int dval,
                           input int vph, input int vval,
                           output int highs, output int stbn, output int stbph, output int stbbad);
        highs = 0; stbn = 0; stbph = -1; stbbad = 0;
        do @(negedge clk); while (phase() != PER - 1);
        for (int i = 0; i < PER; i++) begin
            @(negedge clk);
            if (gate_out) highs++;
            if (sample_stb) begin
                stbn++;
                stbph = i;
                if (!gate_out) stbbad++;
            end
            if (i == oc_on)  oc_flag  = 1'b1;
            if (i == oc_off) oc_flag  = 1'b0;
            if (i == dph)    duty_cmd = 9'(dval);
            if (i == vph)    vin_code = 12'(vval);
        end
    endtask

    initial begin
        int h, sn, sp, sb;
        rst_n = 1'b0; duty_cmd = 9'd200; vin_code = 12'd0; oc_flag = 1'b0;
        repeat (3) @(negedge clk);
        // R9: reset state
        check(gate_out == 1'b0, "R9 gate", int'(gate_out), 0);
        check(sample_stb == 1'b0, "R9 strobe", int'(sample_stb), 0);
        check(lockout == 1'b1, "R9 lockout", int'(lockout), 1);
        rst_n = 1'b1;

        // R4/R5: low input keeps the gate off
        measure(-1, -1, -1, -1, -1, -1, h, sn, sp, sb);
        check(h == 0, "R5 locked highs", h, 0);
        check(lockout == 1'b1, "R4 locked at zero code", int'(lockout), 1);
        // R4: code equal to the rising threshold does not release
        vin_code = 12'(RISE);
        measure(-1, -1, -1, -1, -1, -1, h, sn, sp, sb);
        check(lockout == 1'b1, "R4 at rise threshold", int'(lockout), 1);
        check(h == 0, "R5 highs at rise threshold", h, 0);
        // R6: release mid-period, no partial pulse
        measure(-1, -1, -1, -1, 100, RISE + 1, h, sn, sp, sb);
        check(h == 0, "R6 release period highs", h, 0);
        check(sn == 0, "R6 release period strobes", sn, 0);
        check(lockout == 1'b0, "R4 released above rise", int'(lockout), 0);
        measure(-1, -1, -1, -1, -1, -1, h, sn, sp, sb);
        check(h == 200, "R6 first full period highs", h, 200);

        // Table of pulse patterns
        for (int k = 0; k < NV; k++) begin
            duty_cmd = 9'(VEC[k][0]);
            measure(VEC[k][1], VEC[k][2], VEC[k][3], VEC[k][4], -1, -1, h, sn, sp, sb);
            check(h == VEC[k][5], {TAG[k], " high count"}, h, VEC[k][5]);
            check(sn == ((VEC[k][6] >= 0) ? 1 : 0), {TAG[k], " strobe count"}, sn,
                  (VEC[k][6] >= 0) ? 1 : 0);
            if (VEC[k][6] >= 0)
                check(sp == VEC[k][6], {TAG[k], " strobe phase"}, sp, VEC[k][6]);
            check(sb == 0, "R3 strobe outside pulse", sb, 0);
        end

        // R4: code equal to the falling threshold keeps running
        vin_code = 12'(FALL);
        measure(-1, -1, -1, -1, -1, -1, h, sn, sp, sb);
        check(lockout == 1'b0, "R4 at fall threshold", int'(lockout), 0);
        check(h == 300, "R4 highs at fall threshold", h, 300);
        // R5: lockout taken at phase 50
        measure(-1, -1, -1, -1, 50, FALL - 1, h, sn, sp, sb);
        check(h == 52, "R5 highs after mid-pulse lockout", h, 52);
        check(lockout == 1'b1, "R4 entered below fall", int'(lockout), 1);
        measure(-1, -1, -1, -1, -1, -1, h, sn, sp, sb);
        check(h == 0, "R5 locked period highs", h, 0);
        check(sn == 0, "R5 locked period strobes", sn, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule